// File: doc/BRIEF.md
# Pipelined Ternary-Field Cubing Unit

This block raises an element of the ternary extension field GF(3^97) to the third power. The field is built as polynomials over GF(3) modulo the trinomial f(x) = x^97 + x^12 + 2. A single control bit can negate the operand first, so the unit yields either a(x)^3 or (-a(x))^3. Over a field of characteristic three, cubing is linear. Each output coefficient is therefore a fixed signed sum of a few input coefficients, and the datapath is pure wiring plus small ternary adders.

The connection table is not typed in by hand. At elaboration, a function reduces x^(3i) modulo f(x) for every input position i. For each output digit it records which input digits feed it and whether each one enters negated. That sum is split over two register stages. The first stage adds all but one term. The second stage adds the last term and drives the result. A new operand may be presented on every cycle, and each result appears exactly two cycles after its operand.

Top module: `gf3_cube_pipe`

## Requirements
- R1: Each field digit occupies two bits, with digit i at bits [2i+1:2i]. The low bit is the value mod 2 and the high bit is the value div 2, so 2'b00=0, 2'b01=1 and 2'b10=2. Every digit that leaves the unit uses only these codes when every digit that enters it does.
- R2: With the negate control low, the result equals a(x)·a(x)·a(x) reduced modulo x^97 + x^12 + 2 over GF(3). This covers a zero operand (result zero), the constant 1 (result 1) and the constant 2 (result 2).
- R3: With the negate control high, the result equals (-a(x))^3 mod f(x), where -a swaps each digit between the codes for 1 and 2.
- R4: An operand captured on a rising edge with its valid input high produces its result, with the output valid high, after exactly two further rising edges. In every other cycle the output valid is low.
- R5: Operands presented on consecutive cycles each produce their own correct result, also on consecutive cycles and in the same order.
- R6: In a cycle where no result is delivered, the result bus keeps the last delivered value. The operand and negate inputs have no effect while the valid input is low.
- R7: Synchronous active-high reset clears the output valid and the result bus to zero, and no result appears in the first two cycles after reset is released.
- R8: The result digits obey these closed forms for an unnegated operand: c0 = a0 + a89 + a93, c1 = a65 - a61, c2 = a33, c3 = a1 + a90 + a94 and c96 = a32, all mod 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand and negate control are captured when high |
| in_negate | input | 1 | High selects (-a)^3, low selects a^3 |
| in_poly | input | 194 | Operand, 97 two-bit digits, digit 0 in the low bits |
| out_valid | output | 1 | High in the cycle a result is delivered |
| out_poly | output | 194 | Result, 97 two-bit digits, held between results |

## Verification
The checks on digit codes and on a zero operand mapping to a zero result take for granted that no operand digit carries the unused code 2'b11. A separate check on the input side flags any such digit. The stimulus draws every digit uniformly from 0, 1 and 2, and it also applies directed single-digit and constant operands, so it stays within that assumption. The latency and hold checks count on reset being held until the first operand. The bench holds the valid input low for the whole of reset and keeps changing the operand bus and negate control during idle cycles, so the hold check sees inputs that differ from the ones last captured.

// File: rtl/gf3_cube_pkg.sv
package gf3_cube_pkg;

    // Default field: GF(3)[x] / (x^FIELD_M + x^TAP_K + 2)
    localparam int unsigned FIELD_M   = 97;
    localparam int unsigned TAP_K     = 12;
    // Largest number of input digits feeding one output digit
    localparam int unsigned MAX_TERMS = 3;

    // One GF(3) digit: numeric value of the two bits equals the digit value
    typedef logic [1:0] trit_t;

    // Register contents between the two pipeline stages for one output digit
    typedef struct packed {
        trit_t head;   // sum of all but the last term
        trit_t tail;   // last term, added in the second stage
    } split_t;

    function automatic trit_t trit_neg(input trit_t a);
        return {a[0], a[1]};
    endfunction

    function automatic trit_t trit_add(input trit_t a, input trit_t b);
        logic [2:0] s;
        s = {1'b0, a} + {1'b0, b};
        if (s >= 3'd3) s = s - 3'd3;
        return s[1:0];
    endfunction

endpackage

// File: rtl/gf3_cube_front.sv
// First stage: optional operand negation, term selection from the
// elaboration-time cubing table, partial sum, register.
module gf3_cube_front
    import gf3_cube_pkg::*;
#(
    parameter int unsigned M     = FIELD_M,
    parameter int unsigned K     = TAP_K,
    parameter int unsigned TERMS = MAX_TERMS
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic               in_negate,
    input  logic [2*M-1:0]     in_poly,
    output logic               mid_valid,
    output split_t [M-1:0]     mid_q
);

    localparam int unsigned IDXW = $clog2(M);
    localparam int unsigned TW   = IDXW + 2;          // {used, flip, src}
    localparam int unsigned MAPW = M * TERMS * TW;

    // Reduce x^(3i) mod f for every i and record, for each output digit,
    // up to TERMS contributing input digits with their sign.
    function automatic logic [MAPW-1:0] build_map();
        int         p   [M];
        int         cnt [M];
        int         w0, w1, w2;
        logic [MAPW-1:0] r;
        r = '0;
        for (int j = 0; j < int'(M); j++) begin
            p[j]   = 0;
            cnt[j] = 0;
        end
        p[0] = 1;
        for (int i = 0; i < int'(M); i++) begin
            for (int j = 0; j < int'(M); j++) begin
                if (p[j] != 0) begin
                    if (cnt[j] < int'(TERMS))
                        r[(j*int'(TERMS) + cnt[j])*int'(TW) +: TW] =
                            {1'b1, (p[j] == 2), IDXW'(i)};
                    cnt[j] = cnt[j] + 1;
                end
            end
            // multiply by x^3; x^(M+r) = x^r * (2x^K + 1)
            w0 = p[M-3];
            w1 = p[M-2];
            w2 = p[M-1];
            for (int j = int'(M) - 1; j >= 3; j--) p[j] = p[j-3];
            p[0] = w0;
            p[1] = w1;
            p[2] = w2;
            p[K]   = (p[K]   + 2*w0) % 3;
            p[K+1] = (p[K+1] + 2*w1) % 3;
            p[K+2] = (p[K+2] + 2*w2) % 3;
        end
        return r;
    endfunction

    localparam logic [MAPW-1:0] CUBE_MAP = build_map();

    trit_t  opnd [M];
    split_t [M-1:0] mid_d;

    for (genvar i = 0; i < int'(M); i++) begin : g_opnd
        assign opnd[i] = in_negate ? trit_neg(in_poly[2*i +: 2]) : in_poly[2*i +: 2];
    end

    for (genvar j = 0; j < int'(M); j++) begin : g_digit
        trit_t tv [TERMS];
        trit_t acc;
        for (genvar t = 0; t < int'(TERMS); t++) begin : g_term
            localparam logic [TW-1:0] TD = CUBE_MAP[(j*TERMS + t)*TW +: TW];
            if (TD[TW-1]) begin : g_used
                assign tv[t] = TD[TW-2] ? trit_neg(opnd[TD[IDXW-1:0]])
                                        : opnd[TD[IDXW-1:0]];
            end else begin : g_none
                assign tv[t] = '0;
            end
        end
        always_comb begin
            acc = tv[0];
            for (int t = 1; t < int'(TERMS) - 1; t++) acc = trit_add(acc, tv[t]);
        end
        assign mid_d[j].head = acc;
        assign mid_d[j].tail = tv[TERMS-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mid_valid <= 1'b0;
            mid_q     <= '0;
        end else begin
            mid_valid <= in_valid;
            if (in_valid) mid_q <= mid_d;
        end
    end

endmodule

// File: rtl/gf3_cube_back.sv
// Second stage: final ternary add per digit and result register.
module gf3_cube_back
    import gf3_cube_pkg::*;
#(
    parameter int unsigned M = FIELD_M
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               mid_valid,
    input  split_t [M-1:0]     mid_q,
    output logic               out_valid,
    output logic [2*M-1:0]     out_poly
);

    logic [2*M-1:0] sum_d;

    for (genvar j = 0; j < int'(M); j++) begin : g_sum
        assign sum_d[2*j +: 2] = trit_add(mid_q[j].head, mid_q[j].tail);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_poly  <= '0;
        end else begin
            out_valid <= mid_valid;
            if (mid_valid) out_poly <= sum_d;
        end
    end

endmodule

// File: rtl/gf3_cube_pipe.sv
module gf3_cube_pipe
    import gf3_cube_pkg::*;
#(
    parameter int unsigned M     = FIELD_M,
    parameter int unsigned K     = TAP_K,
    parameter int unsigned TERMS = MAX_TERMS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_negate,
    input  logic [2*M-1:0]   in_poly,
    output logic             out_valid,
    output logic [2*M-1:0]   out_poly
);

    logic           mid_valid;
    split_t [M-1:0] mid_q;

    gf3_cube_front #(.M(M), .K(K), .TERMS(TERMS)) u_front (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_negate (in_negate),
        .in_poly   (in_poly),
        .mid_valid (mid_valid),
        .mid_q     (mid_q)
    );

    gf3_cube_back #(.M(M)) u_back (
        .clk       (clk),
        .rst       (rst),
        .mid_valid (mid_valid),
        .mid_q     (mid_q),
        .out_valid (out_valid),
        .out_poly  (out_poly)
    );

endmodule

// File: rtl/gf3_cube_pipe_chk.sv
module gf3_cube_pipe_chk #(
    parameter int unsigned M = 97
) (
    input logic           clk,
    input logic           rst,
    input logic           in_valid,
    input logic           in_negate,
    input logic [2*M-1:0] in_poly,
    input logic           out_valid,
    input logic [2*M-1:0] out_poly
);

    localparam logic [2*M-1:0] LO_MASK = {M{2'b01}};

    // Rising edges seen since reset was released, saturating at 3
    logic [1:0] age;
    always_ff @(posedge clk) begin
        if (rst)              age <= 2'd0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    logic in_bad, out_bad;
    assign in_bad  = |((in_poly  >> 1) & in_poly  & LO_MASK);
    assign out_bad = |((out_poly >> 1) & out_poly & LO_MASK);

    AST_IN_DIGITS_LEGAL: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> !in_bad);                                                    // R1
    AST_OUT_DIGITS_LEGAL: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !out_bad);                                                  // R1
    AST_LATENCY_TWO: assert property (@(posedge clk) disable iff (rst)
        (age >= 2'd2) |-> (out_valid == $past(in_valid, 2)));                     // R4
    AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        (age < 2'd2) |-> !out_valid);                                             // R7
    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        ((age >= 2'd2) && !$past(in_valid, 2)) |-> $stable(out_poly));            // R6
    AST_ZERO_MAPS_ZERO: assert property (@(posedge clk) disable iff (rst)
        ((age >= 2'd2) && $past(in_valid, 2) && ($past(in_poly, 2) == '0))
            |-> (out_poly == '0));                                                // R2
    AST_UNUSED_NEG: assert property (@(posedge clk) disable iff (rst)
        ((age >= 2'd2) && $past(in_valid, 2) && ($past(in_poly, 2) == '0)
            && $past(in_negate, 2)) |-> out_valid);                               // R3

endmodule

bind gf3_cube_pipe gf3_cube_pipe_chk #(.M(M)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_negate (in_negate),
    .in_poly   (in_poly),
    .out_valid (out_valid),
    .out_poly  (out_poly)
);

// File: tb/tb_gf3_cube_pipe.sv
`timescale 1ns/1ps
module tb_gf3_cube_pipe;

    localparam int NB   = 97;
    localparam int TAPB = 12;
    localparam int DW   = 2*NB;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic          in_negate = 1'b0;
    logic [DW-1:0] in_poly = '0;
    logic          out_valid;
    logic [DW-1:0] out_poly;

    always #5 clk = ~clk;

    gf3_cube_pipe dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_negate (in_negate),
        .in_poly   (in_poly),
        .out_valid (out_valid),
        .out_poly  (out_poly)
    );

    int nvec = 0;
    int nfail = 0;
    bit done = 1'b0;

    // two-deep expectation pipe, plus the held result
    bit            p1_v = 0, p2_v = 0;
    logic [DW-1:0] p1_d = '0, p2_d = '0;
    string         p1_t = "", p2_t = "";
    logic [DW-1:0] held = '0;

    function automatic void ref_mul(input int x[NB], input int y[NB], output int r[NB]);
        int acc [2*NB-1];
        for (int k = 0; k < 2*NB-1; k++) acc[k] = 0;
        for (int i = 0; i < NB; i++)
            for (int j = 0; j < NB; j++)
                acc[i+j] = (acc[i+j] + x[i]*y[j]) % 3;
        for (int k = 2*NB-2; k >= NB; k--) begin
            acc[k-NB+TAPB] = (acc[k-NB+TAPB] + 2*acc[k]) % 3;
            acc[k-NB]      = (acc[k-NB] + acc[k]) % 3;
            acc[k] = 0;
        end
        for (int k = 0; k < NB; k++) r[k] = acc[k];
    endfunction

    function automatic logic [DW-1:0] cube_ref(input logic [DW-1:0] a, input bit ng);
        int v [NB];
        int sq [NB];
        int cb [NB];
        logic [DW-1:0] o;
        for (int i = 0; i < NB; i++) begin
            v[i] = int'(a[2*i +: 2]);
            if (ng) v[i] = (3 - v[i]) % 3;
        end
        ref_mul(v, v, sq);
        ref_mul(sq, v, cb);
        for (int i = 0; i < NB; i++) o[2*i +: 2] = 2'(cb[i]);
        return o;
    endfunction

    function automatic logic [DW-1:0] rand_poly();
        logic [DW-1:0] o;
        for (int i = 0; i < NB; i++) o[2*i +: 2] = 2'($urandom_range(0, 2));
        return o;
    endfunction

    function automatic logic [DW-1:0] unit_poly(input int pos, input int val);
        logic [DW-1:0] o;
        o = '0;
        o[2*pos +: 2] = 2'(val);
        return o;
    endfunction

    function automatic int dg(input logic [DW-1:0] p, input int i);
        return int'(p[2*i +: 2]);
    endfunction

    task automatic report(input bit ok, input string tag, input string what,
                          input logic [DW-1:0] act, input logic [DW-1:0] exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic check_now();
        bit legal;
        legal = 1'b1;
        for (int i = 0; i < NB; i++) if (out_poly[2*i +: 2] == 2'b11) legal = 1'b0;
        report(legal, "R1", "digit code", out_poly, '0);
        if (p2_v) begin
            held = p2_d;
            report(out_valid === 1'b1, "R4", "valid", DW'(out_valid), DW'(1));
            report(out_poly === p2_d, p2_t, "result", out_poly, p2_d);
        end else begin
            report(out_valid === 1'b0, "R4", "idle valid", DW'(out_valid), DW'(0));
            report(out_poly === held, "R6", "hold", out_poly, held);
        end
    endtask

    task automatic step(input bit v, input bit ng, input logic [DW-1:0] d, input string tag);
        @(negedge clk);
        check_now();
        in_valid  = v;
        in_negate = ng;
        in_poly   = d;
        p2_v = p1_v; p2_d = p1_d; p2_t = p1_t;
        p1_v = v;
        p1_d = v ? cube_ref(d, ng) : '0;
        p1_t = tag;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step(1'b0, k[0], rand_poly(), "R6");
    endtask

    task automatic check_forms(input logic [DW-1:0] a);
        step(1'b1, 1'b0, a, "R8");
        idle(2);
        report(dg(out_poly, 0) == (dg(a, 0) + dg(a, 89) + dg(a, 93)) % 3,
               "R8", "c0", DW'(dg(out_poly, 0)), DW'((dg(a, 0) + dg(a, 89) + dg(a, 93)) % 3));
        report(dg(out_poly, 1) == (dg(a, 65) - dg(a, 61) + 3) % 3,
               "R8", "c1", DW'(dg(out_poly, 1)), DW'((dg(a, 65) - dg(a, 61) + 3) % 3));
        report(dg(out_poly, 2) == dg(a, 33),
               "R8", "c2", DW'(dg(out_poly, 2)), DW'(dg(a, 33)));
        report(dg(out_poly, 3) == (dg(a, 1) + dg(a, 90) + dg(a, 94)) % 3,
               "R8", "c3", DW'(dg(out_poly, 3)), DW'((dg(a, 1) + dg(a, 90) + dg(a, 94)) % 3));
        report(dg(out_poly, 96) == dg(a, 32),
               "R8", "c96", DW'(dg(out_poly, 96)), DW'(dg(a, 32)));
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R7: reset state
        report(out_valid === 1'b0, "R7", "reset valid", DW'(out_valid), DW'(0));
        report(out_poly === '0, "R7", "reset result", out_poly, '0);
        rst = 1'b0;
        // R7: nothing delivered right after release
        idle(3);

        // R2: constants
        step(1'b1, 1'b0, '0, "R2");
        step(1'b1, 1'b0, unit_poly(0, 1), "R2");
        step(1'b1, 1'b0, unit_poly(0, 2), "R2");
        // R3: negated constants
        step(1'b1, 1'b1, unit_poly(0, 1), "R3");
        step(1'b1, 1'b1, '0, "R3");
        idle(3);

        // R2: single-digit operands at every position
        for (int i = 0; i < NB; i++) step(1'b1, 1'b0, unit_poly(i, 1 + (i % 2)), "R2");
        idle(2);

        // R5: back-to-back random operands, mixed negation
        for (int n = 0; n < 120; n++) step(1'b1, n[0] ^ n[2], rand_poly(), "R5");
        idle(2);

        // R3: negated random operands
        for (int n = 0; n < 30; n++) step(1'b1, 1'b1, rand_poly(), "R3");

        // R6: sparse operands with idle traffic on the data and negate inputs
        for (int n = 0; n < 40; n++) begin
            step(1'b1, n[1], rand_poly(), "R6");
            idle(1 + (n % 3));
        end

        // R8: closed-form digits
        check_forms(rand_poly());
        check_forms(rand_poly());
        check_forms(unit_poly(93, 1) | unit_poly(89, 2) | unit_poly(61, 1));
        idle(2);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

endmodule